// File: doc/BRIEF.md
# Prefix Byte Instruction Decoder

This block is the byte-level front end of an instruction fetch path. It takes instruction bytes one per cycle over a valid/ready handshake and splits each instruction into three parts: an optional leading prefix byte, a single opcode byte, and an operand of zero to eight bytes. It then presents the whole instruction as one decoded item behind a valid/ready handshake.

The prefix carries three fields: a register-size code, an address-range bit and an instruction-set select. When no prefix is present, all three read as zero. The operand length depends on the opcode. An immediate operand is as wide as the register size. For any other mode, the count comes from a lookup that the surrounding logic computes from the byte on `in_byte` and presents on `op_imm` and `op_bytes` in the cycle the opcode byte is accepted. Operand bytes arrive least significant first, and any byte position not carried reads as zero.

The controller has four states:

- `ST_IDLE` waits for the first byte of an instruction. A prefix byte leads to `ST_AFTER_PFX`. An opcode byte leads to `ST_OPERAND`, or to `ST_HOLD` when no operand follows.
- `ST_AFTER_PFX` takes the opcode. It moves to `ST_OPERAND`, or to `ST_HOLD` when the operand length is zero.
- `ST_OPERAND` collects operand bytes and moves to `ST_HOLD` once the last one is accepted.
- `ST_HOLD` presents the decoded instruction and returns to `ST_IDLE` when the consumer takes it.

Top module: `instr_prefix_decoder`

## Requirements
- R1: In `ST_IDLE`, a byte whose bits 2:0 equal 3'b111 is taken as a prefix. Any other byte is the opcode, and for that instruction the size, address-range and set fields all read as 0.
- R2: Prefix bit 3 appears on `dec_wide_addr`. A value of 0 selects the normal 8/16-bit address range and 1 selects the extended 32/64-bit range.
- R3: Prefix bits 5:4 appear on `dec_size` with this encoding: 0 is 8-bit, 1 is 16-bit, 2 is 32-bit and 3 is 64-bit.
- R4: Prefix bits 7:6 appear on `dec_ext` with this encoding: 0 is the base set, 1 is the graphics set and 3 is the programmable decode array. `dec_err` is 1 exactly when `dec_ext` is the unused code 2.
- R5: When `op_imm` is 1 with the opcode byte, the operand is 2^`dec_size` bytes long: 1, 2, 4 or 8 bytes.
- R6: When `op_imm` is 0, the operand length is `op_bytes`, sampled with the opcode byte. Values above 8 are treated as 8.
- R7: Operand bytes are placed little-endian: the first operand byte goes to `dec_operand[7:0]`. Byte lanes not carried by the current instruction are 0, whatever earlier instructions held.
- R8: `dec_len` equals (1 if a prefix was present, else 0) plus 1 plus the operand length, so it lies between 1 and 10.
- R9: The byte that follows a prefix is always the opcode, even when its bits 2:0 are 3'b111.
- R10: Once `dec_valid` rises, it and every decoded output stay unchanged until `dec_ready` is 1. While `dec_valid` is 1, `in_ready` is 0.
- R11: After reset, `dec_valid` is 0 and `in_ready` is 1. At most one byte is accepted per cycle, and `dec_valid` rises in the cycle after the last byte of an instruction is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | An instruction byte is offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | The decoder accepts the offered byte |
| op_imm | input | 1 | The offered opcode uses an immediate operand |
| op_bytes | input | 4 | Operand length for the offered opcode when it is not immediate |
| dec_valid | output | 1 | A decoded instruction is presented |
| dec_ready | input | 1 | The consumer takes the decoded instruction |
| dec_opcode | output | 8 | Opcode byte |
| dec_size | output | 2 | Register-size code |
| dec_wide_addr | output | 1 | Extended address range selected |
| dec_ext | output | 2 | Instruction-set select |
| dec_err | output | 1 | Unused set-select code seen |
| dec_operand | output | 64 | Assembled operand, with absent lanes reading 0 |
| dec_len | output | 4 | Instruction length in bytes |

## Verification
A wrong state in the controller does not stay hidden. If a prefix is mistaken for an opcode, or the reverse, the opcode and length of that same instruction come out wrong, and every later instruction in the stream is framed wrongly from then on. A wrong byte counter or lane index shows at the next `dec_valid` as a shifted or partly stale operand, together with a wrong `dec_len`. A fault in the hold logic shows within one cycle of a stall: a decoded item is lost or repeated, or a byte is accepted while the decoder is holding. The scoreboard catches each of these as an order or count mismatch.

// File: rtl/pfxdec_pkg.sv
`timescale 1ns/1ps
package pfxdec_pkg;
    localparam int BYTE_W = 8;
    localparam logic [2:0] PFX_MARK     = 3'b111;
    localparam logic [1:0] EXT_RESERVED = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_AFTER_PFX,
        ST_OPERAND,
        ST_HOLD
    } dec_state_e;
endpackage

// File: rtl/pfxdec_fields.sv
`timescale 1ns/1ps
module pfxdec_fields
    import pfxdec_pkg::*;
(
    input  logic [BYTE_W-1:0] pfx,
    output logic [1:0]        size,
    output logic              wide_addr,
    output logic [1:0]        ext,
    output logic              ext_err
);
    always_comb begin
        size      = pfx[5:4];
        wide_addr = pfx[3];
        ext       = pfx[7:6];
        ext_err   = (pfx[7:6] == EXT_RESERVED);
    end
endmodule

// File: rtl/pfxdec_opr_acc.sv
`timescale 1ns/1ps
module pfxdec_opr_acc
    import pfxdec_pkg::*;
#(
    parameter int NBYTES = 8,
    localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     we,
    input  logic [IDX_W-1:0]         idx,
    input  logic [BYTE_W-1:0]        din,
    output logic [NBYTES*BYTE_W-1:0] opr
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                opr[g*BYTE_W +: BYTE_W] <= '0;
            end else if (clr) begin
                opr[g*BYTE_W +: BYTE_W] <= '0;
            end else if (we && (idx == IDX_W'(g))) begin
                opr[g*BYTE_W +: BYTE_W] <= din;
            end
        end
    end
endmodule

// File: rtl/pfxdec_ctrl.sv
`timescale 1ns/1ps
module pfxdec_ctrl
    import pfxdec_pkg::*;
#(
    parameter int NBYTES = 8,
    parameter int CNT_W  = 4,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    input  logic              op_imm,
    input  logic [CNT_W-1:0]  op_bytes,
    input  logic [1:0]        size,
    input  logic              dec_ready,
    output logic              in_ready,
    output logic              dec_valid,
    output logic [BYTE_W-1:0] pfx_q,
    output logic [BYTE_W-1:0] opcode_q,
    output logic [LEN_W-1:0]  len,
    output logic              acc_clr,
    output logic              acc_we,
    output logic [CNT_W-1:0]  got_q
);
    dec_state_e       state, nxt;
    logic             has_pfx;
    logic [CNT_W-1:0] need_q;
    logic [CNT_W-1:0] need_new;
    logic [CNT_W-1:0] imm_bytes;
    logic [CNT_W-1:0] lut_bytes;
    logic             accept;
    logic             is_pfx;
    logic             last_opr;

    assign accept   = in_valid && in_ready;
    assign is_pfx   = (in_byte[2:0] == PFX_MARK);
    assign last_opr = ((got_q + CNT_W'(1)) == need_q);

    always_comb begin
        imm_bytes = CNT_W'(1) << size;
        if (imm_bytes > CNT_W'(NBYTES)) imm_bytes = CNT_W'(NBYTES);
        lut_bytes = (op_bytes > CNT_W'(NBYTES)) ? CNT_W'(NBYTES) : op_bytes;
        need_new  = op_imm ? imm_bytes : lut_bytes;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (accept) begin
                    if (is_pfx)              nxt = ST_AFTER_PFX;
                    else if (need_new == '0) nxt = ST_HOLD;
                    else                     nxt = ST_OPERAND;
                end
            end
            ST_AFTER_PFX: begin
                if (accept) nxt = (need_new == '0) ? ST_HOLD : ST_OPERAND;
            end
            ST_OPERAND: begin
                if (accept && last_opr) nxt = ST_HOLD;
            end
            ST_HOLD: begin
                if (dec_ready) nxt = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            has_pfx  <= 1'b0;
            pfx_q    <= '0;
            opcode_q <= '0;
            need_q   <= '0;
            got_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (accept) begin
                        if (is_pfx) begin
                            pfx_q   <= in_byte;
                            has_pfx <= 1'b1;
                        end else begin
                            opcode_q <= in_byte;
                            need_q   <= need_new;
                            got_q    <= '0;
                        end
                    end
                end
                ST_AFTER_PFX: begin
                    if (accept) begin
                        opcode_q <= in_byte;
                        need_q   <= need_new;
                        got_q    <= '0;
                    end
                end
                ST_OPERAND: begin
                    if (accept) got_q <= got_q + CNT_W'(1);
                end
                ST_HOLD: begin
                    if (dec_ready) begin
                        pfx_q   <= '0;
                        has_pfx <= 1'b0;
                    end
                end
            endcase
        end
    end

    always_comb begin
        in_ready  = (state != ST_HOLD);
        dec_valid = (state == ST_HOLD);
        acc_clr   = accept && (((state == ST_IDLE) && !is_pfx) || (state == ST_AFTER_PFX));
        acc_we    = accept && (state == ST_OPERAND);
        len       = LEN_W'(has_pfx) + LEN_W'(1) + LEN_W'(need_q);
    end
endmodule

// File: rtl/instr_prefix_decoder.sv
`timescale 1ns/1ps
module instr_prefix_decoder
    import pfxdec_pkg::*;
#(
    parameter int NBYTES = 8,
    localparam int OPR_W = NBYTES * BYTE_W,
    localparam int CNT_W = $clog2(NBYTES + 1),
    localparam int LEN_W = $clog2(NBYTES + 3),
    localparam int IDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_byte,
    output logic              in_ready,
    input  logic              op_imm,
    input  logic [CNT_W-1:0]  op_bytes,
    output logic              dec_valid,
    input  logic              dec_ready,
    output logic [BYTE_W-1:0] dec_opcode,
    output logic [1:0]        dec_size,
    output logic              dec_wide_addr,
    output logic [1:0]        dec_ext,
    output logic              dec_err,
    output logic [OPR_W-1:0]  dec_operand,
    output logic [LEN_W-1:0]  dec_len
);
    logic [BYTE_W-1:0] pfx_q;
    logic              acc_clr;
    logic              acc_we;
    logic [CNT_W-1:0]  got_q;

    pfxdec_fields u_fields (
        .pfx       (pfx_q),
        .size      (dec_size),
        .wide_addr (dec_wide_addr),
        .ext       (dec_ext),
        .ext_err   (dec_err)
    );

    pfxdec_ctrl #(.NBYTES(NBYTES), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_byte   (in_byte),
        .op_imm    (op_imm),
        .op_bytes  (op_bytes),
        .size      (dec_size),
        .dec_ready (dec_ready),
        .in_ready  (in_ready),
        .dec_valid (dec_valid),
        .pfx_q     (pfx_q),
        .opcode_q  (dec_opcode),
        .len       (dec_len),
        .acc_clr   (acc_clr),
        .acc_we    (acc_we),
        .got_q     (got_q)
    );

    pfxdec_opr_acc #(.NBYTES(NBYTES)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (acc_clr),
        .we    (acc_we),
        .idx   (got_q[IDX_W-1:0]),
        .din   (in_byte),
        .opr   (dec_operand)
    );
endmodule

// File: rtl/instr_prefix_decoder_chk.sv
`timescale 1ns/1ps
module instr_prefix_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        dec_valid,
    input logic        dec_ready,
    input logic [7:0]  dec_opcode,
    input logic [1:0]  dec_size,
    input logic [1:0]  dec_ext,
    input logic [63:0] dec_operand,
    input logic [3:0]  dec_len
);
    assert_hold_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_ready) |=> (dec_valid && $stable(dec_operand) && $stable(dec_opcode)
                                       && $stable(dec_len) && $stable(dec_size) && $stable(dec_ext)));

    assert_no_accept_in_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> !in_ready);

    assert_len_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_len >= 4'd1 && dec_len <= 4'd10));

    assert_short_zero_operand_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_len == 4'd1) |-> (dec_operand == 64'd0));

    assert_valid_after_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dec_valid) |-> $past(in_valid));
endmodule

bind instr_prefix_decoder instr_prefix_decoder_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .dec_valid   (dec_valid),
    .dec_ready   (dec_ready),
    .dec_opcode  (dec_opcode),
    .dec_size    (dec_size),
    .dec_ext     (dec_ext),
    .dec_operand (dec_operand),
    .dec_len     (dec_len)
);

// File: tb/instr_prefix_decoder_tb_top.sv
`timescale 1ns/1ps
module instr_prefix_decoder_tb_top;
    typedef struct packed {
        logic [7:0]  opc;
        logic [1:0]  size;
        logic        addr;
        logic [1:0]  ext;
        logic        err;
        logic [63:0] opr;
        logic [3:0]  len;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = '0;
    logic        in_ready;
    logic        op_imm = 1'b0;
    logic [3:0]  op_bytes = '0;
    logic        dec_valid;
    logic        dec_ready = 1'b1;
    logic [7:0]  dec_opcode;
    logic [1:0]  dec_size;
    logic        dec_wide_addr;
    logic [1:0]  dec_ext;
    logic        dec_err;
    logic [63:0] dec_operand;
    logic [3:0]  dec_len;

    int   checks = 0;
    int   failures = 0;
    int   pushed = 0;
    int   popped = 0;
    bit   stall_mode = 1'b0;
    int   cyc = 0;
    exp_t expq[$];

    always #2 clk = ~clk;

    instr_prefix_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .op_imm(op_imm), .op_bytes(op_bytes),
        .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_opcode(dec_opcode),
        .dec_size(dec_size), .dec_wide_addr(dec_wide_addr), .dec_ext(dec_ext),
        .dec_err(dec_err), .dec_operand(dec_operand), .dec_len(dec_len)
    );

    task automatic check_eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic imm, input logic [3:0] nb);
        in_valid = 1'b1;
        in_byte  = b;
        op_imm   = imm;
        op_bytes = nb;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic send_instr(input logic has_pfx, input logic [7:0] pfx, input logic [7:0] opc,
                              input logic imm, input logic [3:0] nb, input logic [63:0] opr);
        exp_t e;
        logic [7:0] p;
        int n;
        p = has_pfx ? pfx : 8'h00;
        e.opc  = opc;
        e.size = p[5:4];
        e.addr = p[3];
        e.ext  = p[7:6];
        e.err  = (p[7:6] == 2'b10);
        n = imm ? (1 << p[5:4]) : ((nb > 4'd8) ? 8 : int'(nb));
        e.opr = '0;
        for (int i = 0; i < n; i++) e.opr[i*8 +: 8] = opr[i*8 +: 8];
        e.len = 4'(int'(has_pfx) + 1 + n);
        expq.push_back(e);
        pushed++;
        if (has_pfx) send_byte(pfx, 1'b0, 4'd0);
        send_byte(opc, imm, nb);
        for (int i = 0; i < n; i++) send_byte(opr[i*8 +: 8], 1'b0, 4'd0);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            dec_ready = stall_mode ? ((cyc % 4) == 0) : 1'b1;
        end
    end

    initial begin
        exp_t e;
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && dec_valid) begin
                check_eq("R10 in_ready low while holding", {63'd0, in_ready}, 64'd0);
                if (dec_ready) begin
                    if (expq.size() == 0) begin
                        check_eq("R11 unexpected output item", 64'd1, 64'd0);
                    end else begin
                        e = expq.pop_front();
                        popped++;
                        check_eq("R1 R9 opcode", {56'd0, dec_opcode}, {56'd0, e.opc});
                        check_eq("R3 size", {62'd0, dec_size}, {62'd0, e.size});
                        check_eq("R2 address range", {63'd0, dec_wide_addr}, {63'd0, e.addr});
                        check_eq("R4 set select", {62'd0, dec_ext}, {62'd0, e.ext});
                        check_eq("R4 error flag", {63'd0, dec_err}, {63'd0, e.err});
                        check_eq("R5 R6 R7 operand", dec_operand, e.opr);
                        check_eq("R8 length", {60'd0, dec_len}, {60'd0, e.len});
                    end
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check_eq("R11 reset dec_valid", {63'd0, dec_valid}, 64'd0);
        check_eq("R11 reset in_ready", {63'd0, in_ready}, 64'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R11 idle dec_valid", {63'd0, dec_valid}, 64'd0);

        send_instr(1'b0, 8'h00, 8'h00, 1'b0, 4'd0, 64'h0);                // R1 bare opcode
        send_instr(1'b0, 8'h00, 8'h01, 1'b1, 4'd0, 64'hFFFF_FFFF_FFFF_FFAB); // R5 one byte
        send_instr(1'b1, 8'h37, 8'h09, 1'b1, 4'd0, 64'h1122_3344_5566_7788); // R5 R7 eight bytes
        send_instr(1'b0, 8'h00, 8'h21, 1'b1, 4'd0, 64'hDEAD_BEEF_CAFE_F00D); // R7 stale lanes zero
        send_instr(1'b1, 8'h1F, 8'h10, 1'b1, 4'd0, 64'h0000_0000_0000_A55A); // R2 R3 16-bit
        send_instr(1'b1, 8'h27, 8'h51, 1'b1, 4'd0, 64'h9999_9999_0BAD_F00D); // R3 32-bit
        send_instr(1'b1, 8'h3F, 8'h19, 1'b0, 4'd3, 64'hAAAA_AAAA_AA12_3456); // R6 lookup count
        send_instr(1'b1, 8'h87, 8'h02, 1'b0, 4'd0, 64'h0);                 // R4 unused code
        send_instr(1'b1, 8'h47, 8'h03, 1'b0, 4'd1, 64'h0000_0000_0000_0077); // R4 graphics
        send_instr(1'b1, 8'hC7, 8'h05, 1'b0, 4'd2, 64'h0000_0000_0000_BEEF); // R4 array set
        send_instr(1'b1, 8'h07, 8'h0F, 1'b0, 4'd1, 64'h0000_0000_0000_0042); // R9 marked opcode
        send_instr(1'b0, 8'h00, 8'h93, 1'b0, 4'd15, 64'h0102_0304_0506_0708); // R6 clamp to 8

        stall_mode = 1'b1;                                                   // R10 stalls
        send_instr(1'b1, 8'h3F, 8'hB1, 1'b1, 4'd0, 64'hF0E1_D2C3_B4A5_9687);
        send_instr(1'b0, 8'h00, 8'hE8, 1'b0, 4'd0, 64'h0);
        send_instr(1'b1, 8'h1F, 8'h26, 1'b0, 4'd2, 64'h0000_0000_0000_1357);
        send_instr(1'b0, 8'h00, 8'h0A, 1'b1, 4'd0, 64'h0000_0000_0000_0055);

        while (expq.size() != 0) @(negedge clk);
        stall_mode = 1'b0;
        repeat (4) @(negedge clk);
        check_eq("R10 R11 item count", 64'(popped), 64'(pushed));
        check_eq("R11 idle after drain", {63'd0, dec_valid}, 64'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule